// File: doc/BRIEF.md
# Programmable Input Glitch Filter Bank

This block cleans a set of asynchronous digital input lines before they reach the rest of the chip. Each line has its own filter. A line's filtered output adopts a new input level only after that level has been held for a programmed number of filter ticks. Anything shorter is suppressed.

Every line picks one of four settings through a 2-bit code. Three of the settings are fixed widths, set by parameters and counted in system clocks. At the default 80 MHz clock they give 9, 512 and 204800 cycles, which is 112.5 ns, 6.4 µs and 2.56 ms. The fourth setting is a single custom width shared by every line that selects it. That width is counted in ticks of a shared timebase. The timebase is either an internal 32-bit divider of the system clock or the rising edges of an external timebase pin. A line can also be disabled, and it then passes its synchronised input straight through.

Top module: `glf_bank`

## Requirements
- R1: While rst_n is low, every bit of `dout` is 0 whatever `din` does.
- R2: A disabled line (`line_en[i]`=0) drives `dout[i]` with `din[i]` delayed by exactly three clock edges.
- R3: Line i's setting is `line_sel[2i+1:2i]`: code 0 picks the first fixed width, 1 the second, 2 the third, 3 the shared custom width. Each line uses only its own code.
- R4: With a fixed setting of N cycles, an input pulse held N cycles always reaches `dout`, and one held N-1 cycles never does.
- R5: The custom setting needs `cust_ticks` ticks of the shared timebase: a pulse spanning that many ticks passes and one tick fewer is blocked. A value of 0 behaves as 1.
- R6: With the internal divider in use, the shared timebase ticks once every `cust_div` clock cycles, and every cycle when `cust_div` is 0 or 1.
- R7: The external timebase replaces the divider only while `ext_sel` and `ext_rate_ok` are both 1. In that mode each rising edge of `ext_tb` gives one tick, three clock edges later, and there are no other ticks.
- R8: An enabled line's output never changes on its own. It changes only to the level that `din` had three clock edges earlier, and a steady input leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| din | input | NUM_LINES | Raw asynchronous input lines |
| line_en | input | NUM_LINES | Per-line filter enable |
| line_sel | input | 2*NUM_LINES | Per-line setting code, 2 bits per line |
| cust_div | input | DIV_W | Internal divider period in clock cycles |
| cust_ticks | input | CNT_W | Custom width in timebase ticks |
| ext_tb | input | 1 | External timebase, asynchronous |
| ext_sel | input | 1 | Select the external timebase |
| ext_rate_ok | input | 1 | External timebase rate is configured |
| dout | output | NUM_LINES | Filtered output lines |

## Verification
Some properties are checked on every cycle. A disabled line must follow its input with a fixed three-edge delay. An output may only change to the input level seen three edges earlier. In external mode a tick may only follow a synchronised rising edge. Under a stable internal divider, ticks must be spaced exactly `cust_div` cycles apart. Other behaviour needs the bench's directed pulses. These cover the pass and block boundary at N and N-1 ticks for each setting, the sharing of the custom width between lines, the zero-width clamp, and the rule that the external timebase is used only when both of its enables are set.

// File: rtl/glf_pkg.sv
// Shared definitions for the glitch filter bank.
// Assumes: setting codes are decoded identically by every line.
package glf_pkg;

    // Per-line setting code; the numeric values are the line_sel encoding.
    typedef enum logic [1:0] {
        GLF_SEL_FAST   = 2'd0,
        GLF_SEL_MID    = 2'd1,
        GLF_SEL_SLOW   = 2'd2,
        GLF_SEL_CUSTOM = 2'd3
    } glf_sel_e;

endpackage

// File: rtl/glf_sync.sv
// Two-stage synchroniser for a vector of asynchronous inputs.
// Assumes: each bit is independent; no cross-bit coherence is needed.
module glf_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stage1;

    // Two flops in series; both clear to 0 in reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end

endmodule

// File: rtl/glf_tick_gen.sv
// Shared timebase for the custom filter setting.
// With ext_mode low, an internal divider emits one tick every div_val cycles
// (every cycle for 0 or 1). With ext_mode high, the divider is held and each
// synchronised rising edge of ext_tb is one tick.
// Assumes: ext_tb is asynchronous and its high and low phases last at least
// two clock cycles.
module glf_tick_gen #(
    parameter int DIV_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_val,
    input  logic             ext_tb,
    input  logic             ext_mode,
    output logic             tick
);

    logic [DIV_W-1:0] div_cnt;
    logic             div_tick;
    logic             ext_s;
    logic             ext_d;
    logic             ext_edge;

    glf_sync #(.W(1)) ext_sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (ext_tb),
        .q     (ext_s)
    );

    // Divider tick when the count reaches the programmed period.
    always_comb begin
        div_tick = (div_val <= DIV_W'(1)) || (div_cnt >= div_val - DIV_W'(1));
    end

    // Divider counter; restarts on each tick and parks at 0 in external mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_cnt <= '0;
        end else if (ext_mode || div_tick) begin
            div_cnt <= '0;
        end else begin
            div_cnt <= div_cnt + DIV_W'(1);
        end
    end

    // Delay stage used to find rising edges of the synchronised timebase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ext_d <= 1'b0;
        end else begin
            ext_d <= ext_s;
        end
    end

    // Pick the tick source.
    always_comb begin
        ext_edge = ext_s & ~ext_d;
        tick     = ext_mode ? ext_edge : div_tick;
    end

endmodule

// File: rtl/glf_line.sv
// One filtered line. While enabled, a counter advances on each tick in which
// the synchronised input differs from the output. It clears whenever they
// agree. When the count reaches the selected threshold, the output adopts the
// input. While disabled, the output follows the input and the counter stays 0.
// Assumes: sin is already synchronised and cust_thr is at least 1.
module glf_line
    import glf_pkg::*;
#(
    parameter int CNT_W    = 32,
    parameter int FAST_CYC = 9,
    parameter int MID_CYC  = 512,
    parameter int SLOW_CYC = 204800
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sin,
    input  logic             en,
    input  glf_sel_e         sel,
    input  logic             cust_tick,
    input  logic [CNT_W-1:0] cust_thr,
    output logic             dout
);

    localparam logic [CNT_W-1:0] FAST_THR = CNT_W'(FAST_CYC);
    localparam logic [CNT_W-1:0] MID_THR  = CNT_W'(MID_CYC);
    localparam logic [CNT_W-1:0] SLOW_THR = CNT_W'(SLOW_CYC);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] thr;
    logic             tick;

    // Threshold and tick source for the selected setting.
    always_comb begin
        case (sel)
            GLF_SEL_FAST: thr = FAST_THR;
            GLF_SEL_MID:  thr = MID_THR;
            GLF_SEL_SLOW: thr = SLOW_THR;
            default:      thr = cust_thr;
        endcase
        tick = (sel == GLF_SEL_CUSTOM) ? cust_tick : 1'b1;
    end

    // Persistence counter and filtered output register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            dout <= 1'b0;
        end else if (!en) begin
            cnt  <= '0;
            dout <= sin;
        end else if (sin == dout) begin
            cnt  <= '0;
        end else if (tick) begin
            if (cnt >= thr - CNT_W'(1)) begin
                cnt  <= '0;
                dout <= sin;
            end else begin
                cnt  <= cnt + CNT_W'(1);
            end
        end
    end

endmodule

// File: rtl/glf_bank.sv
// Bank of NUM_LINES glitch filters sharing three fixed widths and one custom
// width timed by a common timebase (internal divider or external pin).
// Assumes: the configuration inputs are quasi-static with respect to clk.
module glf_bank
    import glf_pkg::*;
#(
    parameter int NUM_LINES = 4,
    parameter int DIV_W     = 32,
    parameter int CNT_W     = 32,
    parameter int FAST_CYC  = 9,
    parameter int MID_CYC   = 512,
    parameter int SLOW_CYC  = 204800
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM_LINES-1:0]   din,
    input  logic [NUM_LINES-1:0]   line_en,
    input  logic [2*NUM_LINES-1:0] line_sel,
    input  logic [DIV_W-1:0]       cust_div,
    input  logic [CNT_W-1:0]       cust_ticks,
    input  logic                   ext_tb,
    input  logic                   ext_sel,
    input  logic                   ext_rate_ok,
    output logic [NUM_LINES-1:0]   dout
);

    localparam int SEL_W = 2;

    logic [NUM_LINES-1:0] din_s;
    logic                 ext_mode;
    logic                 cust_tick;
    logic [CNT_W-1:0]     cust_thr;

    // External timebase only when both enables are set; clamp custom width to 1.
    always_comb begin
        ext_mode = ext_sel & ext_rate_ok;
        cust_thr = (cust_ticks == '0) ? CNT_W'(1) : cust_ticks;
    end

    glf_sync #(.W(NUM_LINES)) din_sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (din),
        .q     (din_s)
    );

    glf_tick_gen #(.DIV_W(DIV_W)) tick_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .div_val  (cust_div),
        .ext_tb   (ext_tb),
        .ext_mode (ext_mode),
        .tick     (cust_tick)
    );

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        glf_line #(
            .CNT_W    (CNT_W),
            .FAST_CYC (FAST_CYC),
            .MID_CYC  (MID_CYC),
            .SLOW_CYC (SLOW_CYC)
        ) line_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .sin       (din_s[i]),
            .en        (line_en[i]),
            .sel       (glf_sel_e'(line_sel[SEL_W*i +: SEL_W])),
            .cust_tick (cust_tick),
            .cust_thr  (cust_thr),
            .dout      (dout[i])
        );
    end

endmodule

// File: rtl/glf_bank_chk.sv
// Property checker for glf_bank, attached through bind.
// Assumes: din and ext_tb change away from the rising clock edge.
module glf_bank_chk #(
    parameter int NUM_LINES = 4,
    parameter int DIV_W     = 32
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NUM_LINES-1:0] din,
    input logic [NUM_LINES-1:0] line_en,
    input logic [NUM_LINES-1:0] dout,
    input logic                 ext_tb,
    input logic                 ext_mode,
    input logic                 cust_tick,
    input logic [DIV_W-1:0]     cust_div
);

    logic [2:0]       age;
    logic [DIV_W-1:0] since_tick;
    logic [DIV_W-1:0] prev_div;
    logic             clean;
    logic [DIV_W-1:0] exp_gap;

    // Cycles since reset release, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n)           age <= '0;
        else if (age != 3'd7) age <= age + 3'd1;
    end

    // Gap tracking between ticks and a flag for an undisturbed divider period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_tick <= '0;
            prev_div   <= '0;
            clean      <= 1'b0;
        end else begin
            prev_div   <= cust_div;
            since_tick <= cust_tick ? '0 : since_tick + DIV_W'(1);
            if (ext_mode || cust_div != prev_div) clean <= 1'b0;
            else if (cust_tick)                   clean <= 1'b1;
        end
    end

    // Expected tick spacing minus one.
    always_comb begin
        exp_gap = (cust_div <= DIV_W'(1)) ? '0 : cust_div - DIV_W'(1);
    end

    // External-mode ticks come only from a rising edge seen three edges back.
    assert_ext_tick_edge_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (age >= 3'd4 && ext_mode && cust_tick) |-> ($past(ext_tb, 2) && !$past(ext_tb, 3)));

    // Internal divider spacing under a stable period.
    assert_div_period_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (clean && !ext_mode && cust_tick && cust_div == prev_div) |-> (since_tick == exp_gap));

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_chk
        // Disabled line follows its input after three edges.
        assert_bypass_delay_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (age >= 3'd4 && !$past(line_en[i])) |-> (dout[i] == $past(din[i], 3)));

        // Any output change adopts the input level from three edges back.
        assert_change_from_input_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (age >= 3'd4 && dout[i] != $past(dout[i])) |-> (dout[i] == $past(din[i], 3)));
    end

endmodule

bind glf_bank glf_bank_chk #(
    .NUM_LINES (NUM_LINES),
    .DIV_W     (DIV_W)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .din       (din),
    .line_en   (line_en),
    .dout      (dout),
    .ext_tb    (ext_tb),
    .ext_mode  (ext_mode),
    .cust_tick (cust_tick),
    .cust_div  (cust_div)
);

// File: tb/glf_bank_tb_top.sv
// Directed bench for glf_bank: one task per scenario, each checking its results.
module glf_bank_tb_top;

    localparam int NL    = 4;
    localparam int DW    = 32;
    localparam int CW    = 32;
    localparam int FAST  = 9;
    localparam int MID   = 20;
    localparam int SLOW  = 33;

    logic            clk = 1'b0;
    logic            rst_n;
    logic [NL-1:0]   din;
    logic [NL-1:0]   line_en;
    logic [2*NL-1:0] line_sel;
    logic [DW-1:0]   cust_div;
    logic [CW-1:0]   cust_ticks;
    logic            ext_tb;
    logic            ext_sel;
    logic            ext_rate_ok;
    logic [NL-1:0]   dout;

    logic            ext_run = 1'b0;
    int              ext_ph  = 0;
    int              total   = 0;
    int              bad     = 0;

    glf_bank #(
        .NUM_LINES (NL), .DIV_W (DW), .CNT_W (CW),
        .FAST_CYC (FAST), .MID_CYC (MID), .SLOW_CYC (SLOW)
    ) dut_i (
        .clk (clk), .rst_n (rst_n), .din (din), .line_en (line_en),
        .line_sel (line_sel), .cust_div (cust_div), .cust_ticks (cust_ticks),
        .ext_tb (ext_tb), .ext_sel (ext_sel), .ext_rate_ok (ext_rate_ok),
        .dout (dout)
    );

    // 50 MHz clock.
    always #10 clk = ~clk;

    // External timebase: period 6 cycles (3 high, 3 low) while ext_run is set.
    always @(negedge clk) begin
        if (ext_run) begin
            ext_ph <= (ext_ph == 5) ? 0 : ext_ph + 1;
            ext_tb <= (ext_ph < 3);
        end else begin
            ext_ph <= 0;
            ext_tb <= 1'b0;
        end
    end

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("test done: total=%0d bad=%0d", total, bad);
    endtask

    // Drive din=mask for len cycles, then low for settle cycles; OR dout seen.
    task automatic run_pulse(input logic [NL-1:0] mask, input int len,
                             input int settle, output logic [NL-1:0] seen);
        seen = '0;
        @(negedge clk);
        din = mask;
        for (int k = 0; k < len; k++) begin
            @(negedge clk);
            seen |= dout;
        end
        din = '0;
        for (int k = 0; k < settle; k++) begin
            @(negedge clk);
            seen |= dout;
        end
    endtask

    task automatic set_sel(input int line, input logic [1:0] code);
        line_sel[2*line +: 2] = code;
    endtask

    // R1: outputs held low in reset even with inputs high.
    task automatic t_reset();
        rst_n = 1'b0;
        din   = '1;
        repeat (5) @(negedge clk);
        check("R1", "dout in reset", 32'(dout), 32'h0);
        din = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check("R1", "dout after release", 32'(dout), 32'h0);
    endtask

    // R2: disabled line is a three-edge delay.
    task automatic t_bypass();
        line_en = '0;
        @(negedge clk);
        din[1] = 1'b1;
        @(negedge clk);
        din[1] = 1'b0;
        check("R2", "bypass after 1 edge", 32'(dout[1]), 32'h0);
        @(negedge clk);
        check("R2", "bypass after 2 edges", 32'(dout[1]), 32'h0);
        @(negedge clk);
        check("R2", "bypass after 3 edges", 32'(dout[1]), 32'h1);
        @(negedge clk);
        check("R2", "bypass pulse ends", 32'(dout[1]), 32'h0);
        repeat (4) @(negedge clk);
    endtask

    // R3/R4: fixed widths, N passes and N-1 is blocked.
    task automatic t_presets();
        logic [NL-1:0] seen;
        int            widths [3];
        widths = '{FAST, MID, SLOW};
        line_en = 4'b0001;
        for (int s = 0; s < 3; s++) begin
            set_sel(0, 2'(s));
            run_pulse(4'b0001, widths[s], 2 * widths[s] + 10, seen);
            check("R4", $sformatf("sel %0d N passes", s), 32'(seen[0]), 32'h1);
            check("R4", $sformatf("sel %0d output returns low", s), 32'(dout[0]), 32'h0);
            run_pulse(4'b0001, widths[s] - 1, 2 * widths[s] + 10, seen);
            check("R4", $sformatf("sel %0d N-1 blocked", s), 32'(seen[0]), 32'h0);
        end
    endtask

    // R3/R5: each line obeys its own code; custom shared.
    task automatic t_independent();
        logic [NL-1:0] seen;
        cust_div   = 32'd1;
        cust_ticks = 32'd15;
        line_en    = '1;
        set_sel(0, 2'd0);
        set_sel(1, 2'd1);
        set_sel(2, 2'd2);
        set_sel(3, 2'd3);
        run_pulse('1, MID, 2 * SLOW + 10, seen);
        check("R3", "per-line codes, len MID", 32'(seen), 32'hB);
        run_pulse('1, 15, 2 * SLOW + 10, seen);
        check("R3", "per-line codes, len 15", 32'(seen), 32'h9);
    endtask

    // R5/R6: custom width through divider, shared by two lines.
    task automatic t_custom_div();
        logic [NL-1:0] seen;
        cust_div   = 32'd5;
        cust_ticks = 32'd4;
        line_en    = 4'b0101;
        set_sel(0, 2'd3);
        set_sel(2, 2'd3);
        repeat (6) @(negedge clk);
        run_pulse(4'b0101, 20, 60, seen);
        check("R6", "4 ticks of div 5 pass on both lines", 32'(seen), 32'h5);
        run_pulse(4'b0101, 15, 60, seen);
        check("R5", "3 ticks of div 5 blocked", 32'(seen), 32'h0);
    endtask

    // R5: zero custom width acts as one.
    task automatic t_custom_zero();
        logic [NL-1:0] seen;
        cust_div   = 32'd1;
        cust_ticks = 32'd0;
        line_en    = 4'b0001;
        set_sel(0, 2'd3);
        run_pulse(4'b0001, 1, 10, seen);
        check("R5", "zero width passes 1-cycle pulse", 32'(seen[0]), 32'h1);
        cust_ticks = 32'd2;
        run_pulse(4'b0001, 1, 10, seen);
        check("R5", "width 2 blocks 1 tick", 32'(seen[0]), 32'h0);
        run_pulse(4'b0001, 2, 10, seen);
        check("R5", "width 2 passes 2 ticks", 32'(seen[0]), 32'h1);
    endtask

    // R7: external timebase and its double enable.
    task automatic t_external();
        logic [NL-1:0] seen;
        cust_div    = 32'd1;
        cust_ticks  = 32'd3;
        line_en     = 4'b0001;
        set_sel(0, 2'd3);
        ext_sel     = 1'b1;
        ext_rate_ok = 1'b1;
        repeat (6) @(negedge clk);
        run_pulse(4'b0001, 30, 10, seen);
        check("R7", "no ext edges means no ticks", 32'(seen[0]), 32'h0);
        ext_run = 1'b1;
        repeat (12) @(negedge clk);
        run_pulse(4'b0001, 18, 40, seen);
        check("R7", "3 ext ticks pass", 32'(seen[0]), 32'h1);
        run_pulse(4'b0001, 12, 40, seen);
        check("R7", "2 ext ticks blocked", 32'(seen[0]), 32'h0);
        ext_run     = 1'b0;
        ext_rate_ok = 1'b0;
        repeat (6) @(negedge clk);
        run_pulse(4'b0001, 3, 10, seen);
        check("R7", "rate not set: divider used, 3 passes", 32'(seen[0]), 32'h1);
        run_pulse(4'b0001, 2, 10, seen);
        check("R7", "rate not set: divider used, 2 blocked", 32'(seen[0]), 32'h0);
        ext_sel     = 1'b0;
        ext_rate_ok = 1'b1;
        run_pulse(4'b0001, 3, 10, seen);
        check("R7", "source not selected: divider used", 32'(seen[0]), 32'h1);
        ext_rate_ok = 1'b0;
    endtask

    // R8: steady inputs leave enabled outputs unchanged.
    task automatic t_quiet();
        logic [NL-1:0] seen;
        line_en  = '1;
        line_sel = '0;
        run_pulse('0, 1, 50, seen);
        check("R8", "steady low input, output stays low", 32'(seen), 32'h0);
        @(negedge clk);
        din = '1;
        repeat (FAST + 4) @(negedge clk);
        check("R8", "held high input adopted", 32'(dout), 32'hF);
        seen = '1;
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            seen &= dout;
        end
        check("R8", "steady high input, output stays high", 32'(seen), 32'hF);
        din = '0;
        repeat (FAST + 6) @(negedge clk);
    endtask

    // Watchdog: a hung run is a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog all: actual=timeout expected=finish");
        summary();
        $finish;
    end

    initial begin
        din         = '0;
        line_en     = '0;
        line_sel    = '0;
        cust_div    = 32'd1;
        cust_ticks  = 32'd1;
        ext_sel     = 1'b0;
        ext_rate_ok = 1'b0;
        t_reset();
        t_bypass();
        t_presets();
        t_independent();
        t_custom_div();
        t_custom_zero();
        t_external();
        t_quiet();
        summary();
        $finish;
    end

endmodule